// File: doc/BRIEF.md
# Window and Timeout Watchdog Supervisor

This block supervises a processor by expecting a periodic trigger. It counts a free-running millisecond tick. A 3-bit period code sets the nominal period, and a mode field picks the enforcement policy. Software writes the watchdog register through a strobe that carries a new mode and a new period code. Each such write is also the trigger, and it restarts the period.

In window mode, the trigger must fall in the second half of the period. A trigger that comes too early asks for a system reset, and so does a period that runs out with no trigger. In timeout mode, the counter runs freely and a trigger may come at any time. The first overflow raises a cyclic-interrupt flag, and software clears it with a write-one strobe. An overflow that comes while that flag is still set asks for a reset. A hardware disable pin forces the watchdog off. The reset request is a one-cycle pulse that an external reset generator stretches.

Top module: `wdg_supervisor`

## Requirements
- R1: After the synchronous reset, the stored mode is window (`mode_o` = 2'b01) and the period code is 3'b100, which is 128 ticks. `rst_req_o` and `ci_flag_o` are low. With no trigger, the first reset request is visible 128 clock edges after reset is released, when a tick arrives on every edge.
- R2: The period code maps to these lengths in ticks: 0→8, 1→16, 2→32, 3→64, 4→128, 5→256, 6→1024, 7→4096.
- R3: In window mode with no trigger, `rst_req_o` goes high for one cycle exactly L ticks after the counter restarts, where L is the period length.
- R4: In window mode, a trigger seen while the count is below L/2 raises `rst_req_o` on the next cycle. A trigger at a count of L/2 or more raises no request and restarts the period. When the trigger coincides with the last tick of the period, the trigger wins.
- R5: In timeout mode, an overflow with the flag clear sets `ci_flag_o` and raises no reset request.
- R6: In timeout mode, an overflow while `ci_flag_o` is set raises a one-cycle reset request, and the flag stays set.
- R7: In timeout mode, a trigger at any count raises no request and restarts the period.
- R8: A pulse on `ci_clr` clears `ci_flag_o` on the next cycle. An overflow that sets the flag in the same cycle takes priority.
- R9: While `wd_disable` is high, the effective mode is off (`mode_o` = 2'b00). The counter is held at zero and no reset request or flag set occurs.
- R10: Mode encoding on `wr_mode`: 2'b00 off, 2'b01 window, 2'b10 timeout, 2'b11 off. A write always loads the mode and the period code. The early-trigger test uses the mode and period that were in force before the write.
- R11: Every reset request restarts the counter from zero, so with no trigger the next request in window mode follows exactly L ticks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle millisecond time base strobe |
| wd_disable | input | 1 | Hardware disable; high forces the off mode |
| wr_stb | input | 1 | Watchdog register write; acts as the trigger |
| wr_mode | input | 2 | Mode written with the trigger |
| wr_period | input | 3 | Period code written with the trigger |
| ci_clr | input | 1 | Write-one-to-clear strobe for the cyclic-interrupt flag |
| mode_o | output | 2 | Effective mode (00 off, 01 window, 10 timeout) |
| rst_req_o | output | 1 | One-cycle system reset request |
| ci_flag_o | output | 1 | Cyclic-interrupt flag |

## Verification
The properties assume that `wr_stb`, `ci_clr` and `ms_tick` are one-cycle strobes sampled on the rising edge. They also assume that `wd_disable` is a synchronous level. The stimulus changes every input only on the falling edge, and it pulses each strobe for a single cycle. Every test case starts from a known count: the bench raises the disable pin around the configuring write and drops it afterwards. Because of this, no leftover early-trigger request leaks into the next measured window.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int PCODE_W  = 3;
    localparam int BASE_LEN = 8;
    localparam int CNT_W    = 13;
    localparam logic [PCODE_W-1:0] PCODE_RST = 3'b100;

    typedef enum logic [1:0] {
        WDG_OFF     = 2'b00,
        WDG_WINDOW  = 2'b01,
        WDG_TIMEOUT = 2'b10
    } wdg_mode_e;

    typedef struct packed {
        logic ovf;
        logic first_half;
    } wdg_cnt_stat_t;

    typedef struct packed {
        logic rst_evt;
        logic ci_set;
        logic restart;
    } wdg_evt_t;

    function automatic wdg_mode_e decode_mode(input logic [1:0] raw);
        case (raw)
            2'b01:   return WDG_WINDOW;
            2'b10:   return WDG_TIMEOUT;
            default: return WDG_OFF;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] period_len(input logic [PCODE_W-1:0] code);
        logic [CNT_W-1:0] base;
        base = CNT_W'(BASE_LEN);
        if (code < 3'd6)       return base << code;
        else if (code == 3'd6) return base << 7;
        else                   return base << 9;
    endfunction

endpackage

// File: rtl/wdg_cfg_regs.sv
module wdg_cfg_regs
    import wdg_pkg::*;
#(
    parameter logic [PCODE_W-1:0] RST_CODE = PCODE_RST,
    parameter logic [1:0]         RST_MODE = 2'b01
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wd_disable,
    input  logic               wr_stb,
    input  logic [1:0]         wr_mode,
    input  logic [PCODE_W-1:0] wr_period,
    output wdg_mode_e          eff_mode,
    output logic [CNT_W-1:0]   limit
);
    logic [1:0]         mode_q;
    logic [PCODE_W-1:0] code_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= RST_MODE;
            code_q <= RST_CODE;
        end else if (wr_stb) begin
            mode_q <= wr_mode;
            code_q <= wr_period;
        end
    end

    always_comb begin
        eff_mode = wd_disable ? WDG_OFF : decode_mode(mode_q);
        limit    = period_len(code_q);
    end
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter
    import wdg_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          run,
    input  logic          restart,
    input  logic [W-1:0]  limit,
    output wdg_cnt_stat_t stat
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] last;
    logic         ovf;

    always_comb begin
        last            = limit - 1'b1;
        ovf             = tick && run && (cnt_q == last);
        stat.ovf        = ovf;
        stat.first_half = cnt_q < (limit >> 1);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (restart || ovf || !run)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/wdg_ctrl.sv
module wdg_ctrl
    import wdg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  wdg_mode_e     eff_mode,
    input  logic          wr_stb,
    input  logic          ci_clr,
    input  wdg_cnt_stat_t stat,
    output wdg_evt_t      evt,
    output logic          rst_req_q,
    output logic          ci_q
);
    logic early;
    logic win_exp;
    logic to_exp;

    always_comb begin
        early   = wr_stb && (eff_mode == WDG_WINDOW) && stat.first_half;
        win_exp = !wr_stb && (eff_mode == WDG_WINDOW) && stat.ovf;
        to_exp  = !wr_stb && (eff_mode == WDG_TIMEOUT) && stat.ovf;
        evt.rst_evt = early || win_exp || (to_exp && ci_q);
        evt.ci_set  = to_exp && !ci_q;
        evt.restart = wr_stb || evt.rst_evt || (eff_mode == WDG_OFF);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_req_q <= 1'b0;
            ci_q      <= 1'b0;
        end else begin
            rst_req_q <= evt.rst_evt;
            if (evt.ci_set)
                ci_q <= 1'b1;
            else if (ci_clr)
                ci_q <= 1'b0;
        end
    end
endmodule

// File: rtl/wdg_supervisor.sv
module wdg_supervisor
    import wdg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ms_tick,
    input  logic       wd_disable,
    input  logic       wr_stb,
    input  logic [1:0] wr_mode,
    input  logic [2:0] wr_period,
    input  logic       ci_clr,
    output logic [1:0] mode_o,
    output logic       rst_req_o,
    output logic       ci_flag_o
);
    wdg_mode_e        eff_mode;
    logic [CNT_W-1:0] limit;
    wdg_cnt_stat_t    stat;
    wdg_evt_t         evt;

    wdg_cfg_regs u_cfg (
        .clk        (clk),
        .rst        (rst),
        .wd_disable (wd_disable),
        .wr_stb     (wr_stb),
        .wr_mode    (wr_mode),
        .wr_period  (wr_period),
        .eff_mode   (eff_mode),
        .limit      (limit)
    );

    wdg_counter #(.W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (ms_tick),
        .run     (eff_mode != WDG_OFF),
        .restart (evt.restart),
        .limit   (limit),
        .stat    (stat)
    );

    wdg_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .eff_mode  (eff_mode),
        .wr_stb    (wr_stb),
        .ci_clr    (ci_clr),
        .stat      (stat),
        .evt       (evt),
        .rst_req_q (rst_req_o),
        .ci_q      (ci_flag_o)
    );

    assign mode_o = eff_mode;
endmodule

// File: rtl/wdg_supervisor_sva.sv
module wdg_supervisor_sva
    import wdg_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       wd_disable,
    input logic       ci_clr,
    input logic [1:0] mode_o,
    input logic       rst_req_o,
    input logic       ci_flag_o
);
    // R9
    disable_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        wd_disable |=> !rst_req_o);

    // R5
    ci_only_timeout_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ci_flag_o) |-> ($past(mode_o) == WDG_TIMEOUT));

    // R6
    to_escalate_chk: assert property (@(posedge clk) disable iff (rst)
        (rst_req_o && $past(mode_o) == WDG_TIMEOUT) |-> $past(ci_flag_o));

    // R8
    ci_clear_src_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ci_flag_o) |-> $past(ci_clr));

    // R10
    mode_legal_chk: assert property (@(posedge clk) disable iff (rst)
        mode_o != 2'b11);

    // R9
    off_no_req_chk: assert property (@(posedge clk) disable iff (rst)
        rst_req_o |-> ($past(mode_o) != WDG_OFF));
endmodule

bind wdg_supervisor wdg_supervisor_sva u_sva (
    .clk        (clk),
    .rst        (rst),
    .wd_disable (wd_disable),
    .ci_clr     (ci_clr),
    .mode_o     (mode_o),
    .rst_req_o  (rst_req_o),
    .ci_flag_o  (ci_flag_o)
);

// File: tb/wdg_supervisor_tb.sv
module wdg_supervisor_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ms_tick = 1'b1;
    logic       wd_disable = 1'b0;
    logic       wr_stb = 1'b0;
    logic [1:0] wr_mode = 2'b00;
    logic [2:0] wr_period = 3'b000;
    logic       ci_clr = 1'b0;
    logic [1:0] mode_o;
    logic       rst_req_o;
    logic       ci_flag_o;

    int checks = 0;
    int failures = 0;
    int req_seen = 0;
    int cycles = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    wdg_supervisor u_dut (
        .clk(clk), .rst(rst), .ms_tick(ms_tick), .wd_disable(wd_disable),
        .wr_stb(wr_stb), .wr_mode(wr_mode), .wr_period(wr_period),
        .ci_clr(ci_clr), .mode_o(mode_o), .rst_req_o(rst_req_o),
        .ci_flag_o(ci_flag_o)
    );

    always @(negedge clk) begin
        if (rst_req_o) req_seen++;
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog expired act=%0d exp=<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic int exp_len(input int code);
        if (code < 6) return 8 * (2 ** code);
        if (code == 6) return 1024;
        return 4096;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] m, input logic [2:0] c);
        wr_stb = 1'b1; wr_mode = m; wr_period = c;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic setup(input logic [1:0] m, input logic [2:0] c);
        wd_disable = 1'b1;
        wr(m, c);
        wd_disable = 1'b0;
    endtask

    initial begin
        int base;
        int len;
        wait_n(3);
        rst = 1'b0;
        // R1 reset state
        chk("R1 mode", mode_o, 1);
        chk("R1 req", rst_req_o, 0);
        chk("R1 flag", ci_flag_o, 0);
        wait_n(127);
        chk("R1 no early req", req_seen, 0);
        wait_n(1);
        chk("R1 req at 128", rst_req_o, 1);

        // R2 R3 R11 window expiry per code
        for (int c = 0; c < 8; c++) begin
            len = exp_len(c);
            setup(2'b01, 3'(c));
            base = req_seen;
            wait_n(len - 1);
            chk("R2 R3 none before L", req_seen - base, 0);
            wait_n(1);
            chk("R2 R3 req at L", rst_req_o, 1);
            if (c < 2) begin
                wait_n(1);
                chk("R11 pulse one cycle", rst_req_o, 0);
                wait_n(len - 2);
                chk("R11 quiet", req_seen - base, 1);
                wait_n(1);
                chk("R11 next req at L", rst_req_o, 1);
            end
        end

        // R4 early vs valid triggers
        for (int c = 0; c < 8; c++) begin
            len = exp_len(c);
            for (int k = 0; k < 4; k++) begin
                int d;
                d = (k == 0) ? 0 : (k == 1) ? len/2 - 1 : (k == 2) ? len/2 : len - 1;
                setup(2'b01, 3'(c));
                wait_n(d);
                chk("R4 no req before trigger", rst_req_o, 0);
                wr(2'b01, 3'(c));
                chk("R4 trigger outcome", rst_req_o, (d < len/2) ? 1 : 0);
                if (d >= len/2 && c < 4) begin
                    base = req_seen;
                    wait_n(len - 1);
                    chk("R4 restarted", req_seen - base, 0);
                    wait_n(1);
                    chk("R4 req after new period", rst_req_o, 1);
                end
            end
        end

        // R10 new period takes effect on write; early test uses old settings
        setup(2'b10, 3'd0);
        wr(2'b01, 3'd1);
        chk("R10 timeout-mode write not early", rst_req_o, 0);
        wait_n(15);
        chk("R10 new period quiet", rst_req_o, 0);
        wait_n(1);
        chk("R10 new period req", rst_req_o, 1);

        // R5 R6 timeout
        for (int c = 0; c < 3; c++) begin
            len = exp_len(c);
            ci_clr = 1'b1; setup(2'b10, 3'(c)); ci_clr = 1'b0;
            chk("R5 flag clear at start", ci_flag_o, 0);
            wait_n(len - 1);
            chk("R5 no flag before L", ci_flag_o, 0);
            wait_n(1);
            chk("R5 flag set", ci_flag_o, 1);
            chk("R5 no req", rst_req_o, 0);
            wait_n(len - 1);
            chk("R6 no req early", rst_req_o, 0);
            wait_n(1);
            chk("R6 req on second ovf", rst_req_o, 1);
            chk("R6 flag kept", ci_flag_o, 1);
            wait_n(1);
            chk("R6 req one cycle", rst_req_o, 0);
        end

        // R7 R8 trigger at any time, clear
        ci_clr = 1'b1; setup(2'b10, 3'd1); ci_clr = 1'b0;
        wr(2'b10, 3'd1);
        chk("R7 trigger at zero no req", rst_req_o, 0);
        wait_n(14);
        wr(2'b10, 3'd1);
        chk("R7 late trigger no req", rst_req_o, 0);
        wait_n(15);
        chk("R7 restart no flag", ci_flag_o, 0);
        wait_n(1);
        chk("R7 flag after L", ci_flag_o, 1);
        ci_clr = 1'b1; wait_n(1); ci_clr = 1'b0;
        chk("R8 flag cleared", ci_flag_o, 0);
        wait_n(15);
        chk("R8 flag set again", ci_flag_o, 1);
        chk("R8 first ovf after clear no req", rst_req_o, 0);

        // R9 disable pin
        setup(2'b01, 3'd0);
        wait_n(3);
        wd_disable = 1'b1;
        wait_n(1);
        chk("R9 mode off", mode_o, 0);
        base = req_seen;
        wait_n(50);
        wr(2'b01, 3'd0);
        wait_n(50);
        chk("R9 no req while disabled", req_seen - base, 0);
        wd_disable = 1'b0;
        wait_n(7);
        chk("R9 counter held at zero", rst_req_o, 0);
        wait_n(1);
        chk("R9 req L after enable", rst_req_o, 1);

        // R10 encoding 11 is off
        ci_clr = 1'b1; setup(2'b11, 3'd0); ci_clr = 1'b0;
        chk("R10 mode 11 off", mode_o, 0);
        base = req_seen;
        wait_n(100);
        wr(2'b11, 3'd0);
        wait_n(5);
        chk("R10 no req in 11", req_seen - base, 0);
        chk("R10 no flag in 11", ci_flag_o, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule